// File: doc/BRIEF.md
# Self-Timed Page Commit Controller

This block sits behind a two-wire serial memory slave and turns a finished write transaction into a commit of the gathered bytes into the storage array. While the transaction runs, the slave front end loads incoming data bytes into a small page buffer, one lane at a time, and each loaded lane is marked valid. When the front end reports a stop condition that ends a write carrying data, the block latches the page address and raises busy. It then holds busy for a fixed number of clocks that stands in for the program time.

While busy, the block refuses further lane loads and stop events. It also forces the slave's address acknowledge low, so a master that polls with a write-mode address gets no acknowledge until the commit is over. In the last busy clock it drives one byte-lane write enable per valid lane, so that lanes never loaded keep their old array contents. In the next clock busy falls, a one-clock done pulse appears and the valid mask is cleared. The program time is the parameter `WRITE_CYCLES`, so a bench can run with a short value.

Top module: `nvw_commit`

## Requirements
- R1: A `stop_seen` pulse sampled while idle, with at least one valid lane, raises `busy` from the next clock on.
- R2: A `stop_seen` pulse sampled while idle with no valid lane (`pend_mask` zero) starts nothing: `busy`, `arr_we` and `done` stay low.
- R3: Once raised, `busy` stays high for exactly `WRITE_CYCLES` consecutive clocks.
- R4: `arr_we` is zero except in the last busy clock. In that clock bit i equals the valid flag of lane i, `arr_wdata[8*i+7:8*i]` carries the byte last loaded into lane i, and `arr_page` carries the page latched at the start.
- R5: `done` is high for exactly one clock, the first clock after `busy` falls. In that same clock `pend_mask` is already zero.
- R6: `addr_ack` follows `addr_hit` while idle and is held low in every busy clock.
- R7: Lane loads (`lane_wr`) and `stop_seen` pulses that arrive while busy are ignored. They add no valid lane, change no committed byte and do not extend the busy time.
- R8: A lane loaded more than once before the stop commits its last byte. Array bytes of lanes not marked valid are left unwritten.
- R9: `arr_page` is the value of `page_in` sampled with the starting stop. Later changes of `page_in` during busy do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_wr | input | 1 | Load one data byte into the page buffer |
| lane_idx | input | $clog2(LANES) | Lane selected for the load |
| lane_data | input | DATA_W | Byte to load |
| page_in | input | PAGE_W | Page address of the current transaction |
| stop_seen | input | 1 | Stop condition ending a write transaction |
| addr_hit | input | 1 | Front end matched its own device address |
| addr_ack | output | 1 | Acknowledge permitted for the matched address |
| busy | output | 1 | Commit in progress |
| pend_mask | output | LANES | Lanes currently marked valid |
| arr_we | output | LANES | Per-lane array write enables |
| arr_page | output | PAGE_W | Page address for the array write |
| arr_wdata | output | LANES*DATA_W | Lane data for the array write |
| done | output | 1 | One-clock commit completion pulse |

## Verification
The bench sweeps every valid-lane mask of a four-lane configuration over every page, with a short program time. The empty mask shows that a stop after an address-only write starts nothing. Full and partial masks show that only the marked lanes reach the array, which the bench checks against a mirror of the whole array. Some sweeps load a lane twice before the stop, which shows last-write-wins. Others inject loads, stops and page changes during busy, which separates a correct lockout from one that restarts the timer, marks new lanes or repages the commit. Polling with the address held matched throughout each commit tells apart acknowledge gating that tracks busy exactly from gating that is one clock off.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_PROG = 1'b1
   } nvw_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/nvw_lane_buf.sv
module nvw_lane_buf #(
   parameter int unsigned LANES  = 16,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = $clog2(LANES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_en,
   input  logic [IDX_W-1:0]        load_idx,
   input  logic [DATA_W-1:0]       load_data,
   input  logic                    clear,
   output logic [LANES-1:0]        valid,
   output logic [LANES*DATA_W-1:0] data_flat
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(l);
      logic              hit;
      logic              vld_q;
      logic [DATA_W-1:0] dat_q;

      assign hit = load_en && (load_idx == MY_IDX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
         end else if (clear) begin
            vld_q <= 1'b0;
         end else if (hit) begin
            vld_q <= 1'b1;
            dat_q <= load_data;
         end
      end

      assign valid[l]                          = vld_q;
      assign data_flat[l*DATA_W +: DATA_W]     = dat_q;
   end

endmodule

// File: rtl/nvw_cycle_timer.sv
module nvw_cycle_timer
   import nvw_pkg::*;
#(
   parameter int unsigned WRITE_CYCLES = 1250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last,
   output logic done
);

   localparam int unsigned CNT_W = cnt_width(WRITE_CYCLES);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITE_CYCLES - 1);

   nvw_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   assign busy = (state_q == ST_PROG);
   assign last = busy && (cnt_q == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_PROG;
                  cnt_q   <= '0;
               end
            end
            ST_PROG: begin
               if (last) begin
                  state_q <= ST_IDLE;
                  done    <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nvw_ack_gate.sv
module nvw_ack_gate (
   input  logic addr_hit,
   input  logic busy,
   output logic addr_ack
);

   assign addr_ack = addr_hit && !busy;

endmodule

// File: rtl/nvw_commit.sv
module nvw_commit #(
   parameter int unsigned LANES        = 16,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned PAGE_W       = 7,
   parameter int unsigned WRITE_CYCLES = 1250000,
   localparam int unsigned IDX_W       = $clog2(LANES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lane_wr,
   input  logic [IDX_W-1:0]        lane_idx,
   input  logic [DATA_W-1:0]       lane_data,
   input  logic [PAGE_W-1:0]       page_in,
   input  logic                    stop_seen,
   input  logic                    addr_hit,
   output logic                    addr_ack,
   output logic                    busy,
   output logic [LANES-1:0]        pend_mask,
   output logic [LANES-1:0]        arr_we,
   output logic [PAGE_W-1:0]       arr_page,
   output logic [LANES*DATA_W-1:0] arr_wdata,
   output logic                    done
);

   if (LANES < 2 || (1 << IDX_W) != LANES) begin : g_bad_lanes
      $error("nvw_commit: LANES must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("nvw_commit: DATA_W must be at least 1");
   end
   if (PAGE_W < 1) begin : g_bad_page
      $error("nvw_commit: PAGE_W must be at least 1");
   end
   if (WRITE_CYCLES < 2) begin : g_bad_cycles
      $error("nvw_commit: WRITE_CYCLES must be at least 2");
   end

   logic              start;
   logic              last;
   logic              load_en;
   logic [LANES-1:0]  valid;
   logic [PAGE_W-1:0] page_q;

   assign load_en = lane_wr && !busy;
   assign start   = stop_seen && !busy && (|valid);

   nvw_lane_buf #(
      .LANES  (LANES),
      .DATA_W (DATA_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en),
      .load_idx  (lane_idx),
      .load_data (lane_data),
      .clear     (last),
      .valid     (valid),
      .data_flat (arr_wdata)
   );

   nvw_cycle_timer #(
      .WRITE_CYCLES (WRITE_CYCLES)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .last  (last),
      .done  (done)
   );

   nvw_ack_gate u_gate (
      .addr_hit (addr_hit),
      .busy     (busy),
      .addr_ack (addr_ack)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (start) begin
         page_q <= page_in;
      end
   end

   assign arr_page  = page_q;
   assign arr_we    = last ? valid : '0;
   assign pend_mask = valid;

endmodule

// File: rtl/nvw_commit_chk.sv
module nvw_commit_chk #(
   parameter int unsigned LANES        = 16,
   parameter int unsigned PAGE_W       = 7,
   parameter int unsigned WRITE_CYCLES = 1250000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lane_wr,
   input logic              stop_seen,
   input logic              addr_hit,
   input logic              addr_ack,
   input logic              busy,
   input logic [LANES-1:0]  pend_mask,
   input logic [LANES-1:0]  arr_we,
   input logic [PAGE_W-1:0] arr_page,
   input logic              done
);

   logic [31:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 1;
      else           busy_len <= '0;
   end

   a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_seen && !busy && (|pend_mask)) |=> busy);

   a_r2_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_seen && !busy && (pend_mask == '0)) |=> !busy);

   a_r3_busy_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < WRITE_CYCLES));

   a_r3_busy_len_exact: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_len == WRITE_CYCLES));

   a_r4_we_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (|arr_we) |-> (busy && arr_we == pend_mask));

   a_r4_we_then_done: assert property (@(posedge clk) disable iff (!rst_n)
      (|arr_we) |=> done);

   a_r5_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && pend_mask == '0 && $past(busy)));

   a_r6_ack_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !addr_ack);

   a_r6_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (addr_ack == addr_hit));

   a_r7_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && lane_wr && (arr_we == '0)) |=> $stable(pend_mask));

   a_r9_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(arr_page));

endmodule

bind nvw_commit nvw_commit_chk #(
   .LANES        (LANES),
   .PAGE_W       (PAGE_W),
   .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lane_wr   (lane_wr),
   .stop_seen (stop_seen),
   .addr_hit  (addr_hit),
   .addr_ack  (addr_ack),
   .busy      (busy),
   .pend_mask (pend_mask),
   .arr_we    (arr_we),
   .arr_page  (arr_page),
   .done      (done)
);

// File: tb/nvw_commit_bench.sv
module nvw_commit_bench;

   localparam int LANES  = 4;
   localparam int DATA_W = 8;
   localparam int PAGE_W = 3;
   localparam int CYC    = 6;
   localparam int IDX_W  = $clog2(LANES);
   localparam int PAGES  = 1 << PAGE_W;
   localparam int WORDS  = PAGES * LANES;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    lane_wr = 1'b0;
   logic [IDX_W-1:0]        lane_idx = '0;
   logic [DATA_W-1:0]       lane_data = '0;
   logic [PAGE_W-1:0]       page_in = '0;
   logic                    stop_seen = 1'b0;
   logic                    addr_hit = 1'b0;
   logic                    addr_ack;
   logic                    busy;
   logic [LANES-1:0]        pend_mask;
   logic [LANES-1:0]        arr_we;
   logic [PAGE_W-1:0]       arr_page;
   logic [LANES*DATA_W-1:0] arr_wdata;
   logic                    done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [DATA_W-1:0] mirror  [WORDS];
   logic [DATA_W-1:0] exp_mem [WORDS];

   always #2 clk = ~clk;

   nvw_commit #(
      .LANES        (LANES),
      .DATA_W       (DATA_W),
      .PAGE_W       (PAGE_W),
      .WRITE_CYCLES (CYC)
   ) u_nvw_commit (
      .clk       (clk),
      .rst_n     (rst_n),
      .lane_wr   (lane_wr),
      .lane_idx  (lane_idx),
      .lane_data (lane_data),
      .page_in   (page_in),
      .stop_seen (stop_seen),
      .addr_hit  (addr_hit),
      .addr_ack  (addr_ack),
      .busy      (busy),
      .pend_mask (pend_mask),
      .arr_we    (arr_we),
      .arr_page  (arr_page),
      .arr_wdata (arr_wdata),
      .done      (done)
   );

   // array mirror built from the write-enable outputs
   always @(negedge clk) begin
      cycles <= cycles + 1;
      for (int l = 0; l < LANES; l++)
         if (arr_we[l])
            mirror[int'(arr_page) * LANES + l] = arr_wdata[l*DATA_W +: DATA_W];
   end

   initial begin
      wait (cycles > 100000);
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic load(input int lane, input logic [DATA_W-1:0] val);
      lane_wr   = 1'b1;
      lane_idx  = IDX_W'(lane);
      lane_data = val;
      @(negedge clk);
      lane_wr   = 1'b0;
   endtask

   task automatic run_tx(input int mask, input int page, input int seed,
                         input bit intrude, input bit dup);
      int busy_cnt = 0, we_hits = 0, we_at = -1, done_hits = 0, done_at = -1;
      int ack_err = 0, page_err = 0, data_err = 0, clr_err = 0;
      logic [LANES-1:0] we_val = '0;
      int expect_busy;
      for (int l = 0; l < LANES; l++) begin
         if (mask[l]) begin
            logic [DATA_W-1:0] v;
            v = DATA_W'(page * 37 + l * 11 + seed * 5 + 1);
            if (dup) load(l, 8'h5A);
            load(l, v);
            exp_mem[page * LANES + l] = v;
         end
      end
      page_in   = PAGE_W'(page);
      stop_seen = 1'b1;
      addr_hit  = 1'b1;
      @(negedge clk);
      stop_seen = 1'b0;
      for (int i = 0; i < CYC + 3; i++) begin
         if (busy) busy_cnt++;
         if (addr_ack != !busy) ack_err++;
         if (arr_we != '0) begin
            we_hits++; we_at = i; we_val = arr_we;
            if (arr_page != PAGE_W'(page)) page_err++;
            for (int l = 0; l < LANES; l++)
               if (arr_we[l] && arr_wdata[l*DATA_W +: DATA_W] != DATA_W'(page * 37 + l * 11 + seed * 5 + 1))
                  data_err++;
         end
         if (done) begin
            done_hits++; done_at = i;
            if (busy || pend_mask != '0) clr_err++;
         end
         if (intrude && i == 2) begin
            lane_wr = 1'b1; lane_idx = '0; lane_data = 8'hEE;
            stop_seen = 1'b1; page_in = ~PAGE_W'(page);
         end
         if (intrude && i == 3) begin
            lane_wr = 1'b0; stop_seen = 1'b0;
         end
         @(negedge clk);
      end
      addr_hit = 1'b0;
      expect_busy = (mask != 0) ? CYC : 0;
      check("R1/R2/R3/R7", "busy clocks", busy_cnt, expect_busy);
      check("R4", "write enable pulses", we_hits, (mask != 0) ? 1 : 0);
      check("R5", "done pulses", done_hits, (mask != 0) ? 1 : 0);
      check("R6", "ack mismatches", ack_err, 0);
      if (mask != 0) begin
         check("R4", "write enable clock", we_at, CYC - 1);
         check("R4/R7", "write enable lanes", we_val, mask);
         check("R4/R8", "write data errors", data_err, 0);
         check("R9", "page errors", page_err, 0);
         check("R5", "done clock", done_at, CYC);
         check("R5", "mask not clear at done", clr_err, 0);
      end
      check("R7", "pending mask after tx", pend_mask, 0);
      @(negedge clk);
      for (int w = 0; w < WORDS; w++)
         if (mirror[w] !== exp_mem[w])
            check("R8", $sformatf("array word %0d", w), mirror[w], exp_mem[w]);
      checks++;
   endtask

   initial begin
      for (int w = 0; w < WORDS; w++) begin
         mirror[w]  = '0;
         exp_mem[w] = '0;
      end
      repeat (3) @(negedge clk);
      addr_hit = 1'b1;
      #1;
      check("R6", "reset busy", busy, 0);
      check("R5", "reset done", done, 0);
      check("R4", "reset write enable", arr_we, 0);
      check("R5", "reset mask", pend_mask, 0);
      check("R6", "reset ack", addr_ack, 1);
      rst_n = 1'b1;
      addr_hit = 1'b0;
      @(negedge clk);
      for (int p = 0; p < PAGES; p++)
         for (int m = 0; m < (1 << LANES); m++)
            run_tx(m, p, p + m, (m % 3) == 1, (m % 4) == 3);
      // a second full sweep over page 5 with fresh data: old lanes must survive
      for (int m = 1; m < (1 << LANES); m++)
         run_tx(m, 5, 50 + m, 1'b1, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule